// File: doc/BRIEF.md
# Double-Buffered Four-Channel DAC Register Bank

This block sits between a host register bus and four DAC converters. It keeps, per channel, a data register that the host fills ahead of time and a live code that drives the converter. It also keeps a shared control word that sets the gain and polarity of each channel. Control settings are staged by a write and only become active when the host reads the control address. In buffered mode, the staged data codes move to the live codes only when the host reads the mode register, so all channels change in the same cycle. In direct mode, each data write reaches its output one cycle later.

The host issues one access per cycle: `host_req` marks the access, and `host_we` selects a write (1) or a read (0). A read exists only for its side effect, so the block returns no read data. The converters themselves and any range tables lie outside the block. Its outputs are the held codes and two per-channel level lines, one for gain and one for bipolar.

Top module: `dac_dbuf_bank`

## Requirements
- R1: After reset, and after any later assertion of the active-low `rst_n`, every code, gain and bipolar output is 0. The staged data and the live codes are also cleared, so enabling the converters or transferring afterwards still yields code 0.
- R2: The mode register is at byte offset 0x02, and its bit 1 enables the converters. While that bit is 0, every channel's code output is 0. Setting the bit again shows the live codes unchanged. The enable bit does not gate the gain and bipolar outputs.
- R3: When bit 0 of the mode register is 0 (direct mode), a write to offset 0x14 + 2*x sets channel x's code on the next cycle. Channels other than x keep their codes.
- R4: When bit 0 of the mode register is 1 (buffered mode), writes to the data offsets leave every code output unchanged.
- R5: In buffered mode, a read of offset 0x02 copies all four staged data registers to the live codes, and all four take effect on the following cycle.
- R6: In direct mode, a read of offset 0x02 changes no output, even when the staged data differs from the live codes.
- R7: A write to the control offset 0x12 changes no gain or bipolar output. A read of 0x12 applies the staged word on the next cycle: bit 11-x drives `gain_out[x]` and bit 7-x drives `bipolar_out[x]`.
- R8: Writing 0 to 0x12 and then reading 0x12 clears every gain and bipolar output. Writing 0 to 0x02 returns every code output to 0.
- R9: A data write keeps only the low DATA_W bits (12 by default) of `host_wdata`. Writes to unmapped offsets such as 0x30 have no effect. Reads of the data offsets have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_req | input | 1 | Access strobe, one access per cycle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Byte offset of the access |
| host_wdata | input | 16 | Write data |
| code_out | output | NUM_CH*DATA_W | Live codes, channel x in bits x*DATA_W upward |
| gain_out | output | NUM_CH | Active gain select per channel |
| bipolar_out | output | NUM_CH | Active bipolar select per channel |

## Verification
The embedded properties check four things on every cycle:
- In buffered mode, a live code changes only on a transfer read.
- A direct-mode write lands on its channel one cycle later.
- A transfer copies the staged values exactly.
- Gain and polarity move only after a control read, and a disabling mode write forces every code to zero.

Some behaviours need a sequence of accesses, so only the bench scenarios can show them:
- The all-channels-together timing of a transfer.
- The reversed bit positions of the control word.
- Staged data surviving a mode switch without a transfer.
- The masking of wide data.
- A mid-run reset clearing the staged values as well as the live ones.

// File: rtl/dacb_pkg.sv
package dacb_pkg;

   // Byte offsets decoded by the bank.
   localparam int unsigned OFS_MODE   = 32'h02;
   localparam int unsigned OFS_CTLW   = 32'h12;
   localparam int unsigned OFS_DATA0  = 32'h14;
   localparam int unsigned OFS_STRIDE = 2;

   // Mode register bit positions.
   localparam int unsigned MODE_EN_BIT  = 1;
   localparam int unsigned MODE_BUF_BIT = 0;

   // Control word bases; channel x sits at base minus x.
   localparam int unsigned CTLW_GAIN_TOP = 11;
   localparam int unsigned CTLW_BIP_TOP  = 7;

   localparam int unsigned HOST_DW = 16;

   typedef struct packed {
      logic mode_wr;
      logic mode_rd;
      logic ctlw_wr;
      logic ctlw_rd;
   } dacb_strobe_t;

   function automatic int unsigned gain_pos(input int unsigned ch);
      return CTLW_GAIN_TOP - ch;
   endfunction

   function automatic int unsigned bip_pos(input int unsigned ch);
      return CTLW_BIP_TOP - ch;
   endfunction

endpackage

// File: rtl/dacb_decode.sv
module dacb_decode
   import dacb_pkg::*;
#(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned NUM_CH = 4
) (
   input  logic              req,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   output dacb_strobe_t      st,
   output logic [NUM_CH-1:0] data_wr
);

   localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(OFS_MODE);
   localparam logic [ADDR_W-1:0] A_CTLW = ADDR_W'(OFS_CTLW);

   if (ADDR_W < 5 || ADDR_W > 16) begin : g_bad_addr
      $error("dacb_decode: ADDR_W must lie in 5..16");
   end

   logic wr_cyc;
   logic rd_cyc;

   assign wr_cyc = req & we;
   assign rd_cyc = req & ~we;

   assign st.mode_wr = wr_cyc & (addr == A_MODE);
   assign st.mode_rd = rd_cyc & (addr == A_MODE);
   assign st.ctlw_wr = wr_cyc & (addr == A_CTLW);
   assign st.ctlw_rd = rd_cyc & (addr == A_CTLW);

   for (genvar i = 0; i < NUM_CH; i++) begin : g_data_dec
      localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA0 + OFS_STRIDE * i);
      assign data_wr[i] = wr_cyc & (addr == A_DATA);
   end

endmodule

// File: rtl/dacb_ctrl.sv
module dacb_ctrl
   import dacb_pkg::*;
#(
   parameter int unsigned NUM_CH = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  dacb_strobe_t       st,
   input  logic [HOST_DW-1:0] wdata,
   output logic               dac_en,
   output logic               buf_mode,
   output logic [NUM_CH-1:0]  gain_act,
   output logic [NUM_CH-1:0]  bip_act
);

   if (NUM_CH < 1 || NUM_CH > 4) begin : g_bad_ch
      $error("dacb_ctrl: NUM_CH must lie in 1..4");
   end

   logic [NUM_CH-1:0] gain_pend;
   logic [NUM_CH-1:0] bip_pend;
   logic [NUM_CH-1:0] gain_in;
   logic [NUM_CH-1:0] bip_in;
   logic              unused_wbits;

   assign unused_wbits = ^wdata;

   always_comb begin
      for (int i = 0; i < NUM_CH; i++) begin
         gain_in[i] = wdata[gain_pos(i)];
         bip_in[i]  = wdata[bip_pos(i)];
      end
   end

   // Mode register: direct effect on write.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dac_en   <= 1'b0;
         buf_mode <= 1'b0;
      end else if (st.mode_wr) begin
         dac_en   <= wdata[MODE_EN_BIT];
         buf_mode <= wdata[MODE_BUF_BIT];
      end
   end

   // Staged control word.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gain_pend <= '0;
         bip_pend  <= '0;
      end else if (st.ctlw_wr) begin
         gain_pend <= gain_in;
         bip_pend  <= bip_in;
      end
   end

   // Active settings follow a read of the control offset.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gain_act <= '0;
         bip_act  <= '0;
      end else if (st.ctlw_rd) begin
         gain_act <= gain_pend;
         bip_act  <= bip_pend;
      end
   end

   AST_CTL_ONLY_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
      !st.ctlw_rd |=> ($stable(gain_act) && $stable(bip_act))); // R7

endmodule

// File: rtl/dacb_chan.sv
module dacb_chan #(
   parameter int unsigned DATA_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              buf_mode,
   input  logic              xfer,
   input  logic              dac_en,
   output logic [DATA_W-1:0] code
);

   if (DATA_W < 1 || DATA_W > 16) begin : g_bad_dw
      $error("dacb_chan: DATA_W must lie in 1..16");
   end

   logic [DATA_W-1:0] staged;
   logic [DATA_W-1:0] live;
   logic              do_xfer;
   logic              do_direct;

   assign do_xfer   = buf_mode & xfer;
   assign do_direct = ~buf_mode & wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         staged <= '0;
      end else if (wr) begin
         staged <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         live <= '0;
      end else if (do_direct) begin
         live <= wdata;
      end else if (do_xfer) begin
         live <= staged;
      end
   end

   assign code = dac_en ? live : '0;

   AST_BUF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_mode && !xfer) |=> $stable(live)); // R4

   AST_DIRECT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (!buf_mode && wr) |=> (live == $past(wdata))); // R3

   AST_XFER_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_mode && xfer) |=> (live == $past(staged))); // R5

   AST_DIRECT_NO_XFER: assert property (@(posedge clk) disable iff (!rst_n)
      (!buf_mode && !wr) |=> $stable(live)); // R6

endmodule

// File: rtl/dac_dbuf_bank.sv
module dac_dbuf_bank
   import dacb_pkg::*;
#(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned DATA_W = 12
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     host_req,
   input  logic                     host_we,
   input  logic [ADDR_W-1:0]        host_addr,
   input  logic [15:0]              host_wdata,
   output logic [NUM_CH*DATA_W-1:0] code_out,
   output logic [NUM_CH-1:0]        gain_out,
   output logic [NUM_CH-1:0]        bipolar_out
);

   localparam int unsigned CODE_W = NUM_CH * DATA_W;

   dacb_strobe_t      st;
   logic [NUM_CH-1:0] data_wr;
   logic              dac_en;
   logic              buf_mode;

   dacb_decode #(
      .ADDR_W (ADDR_W),
      .NUM_CH (NUM_CH)
   ) u_decode (
      .req     (host_req),
      .we      (host_we),
      .addr    (host_addr),
      .st      (st),
      .data_wr (data_wr)
   );

   dacb_ctrl #(
      .NUM_CH (NUM_CH)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .st       (st),
      .wdata    (host_wdata),
      .dac_en   (dac_en),
      .buf_mode (buf_mode),
      .gain_act (gain_out),
      .bip_act  (bipolar_out)
   );

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      dacb_chan #(
         .DATA_W (DATA_W)
      ) u_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr       (data_wr[i]),
         .wdata    (host_wdata[DATA_W-1:0]),
         .buf_mode (buf_mode),
         .xfer     (st.mode_rd),
         .dac_en   (dac_en),
         .code     (code_out[i*DATA_W +: DATA_W])
      );
   end

   AST_DISABLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (host_req && host_we && (host_addr == ADDR_W'(OFS_MODE)) && !host_wdata[MODE_EN_BIT])
      |=> (code_out == CODE_W'(0))); // R2

endmodule

// File: tb/sim_dac_dbuf_bank.sv
module sim_dac_dbuf_bank;

   localparam int CLK_PERIOD = 10;

   typedef struct packed {
      logic [3:0]  req;
      logic        we;
      logic [7:0]  addr;
      logic [15:0] wd;
      logic [47:0] code;
      logic [3:0]  gn;
      logic [3:0]  bp;
   } vec_t;

   localparam logic [47:0] C1 = 48'h123000000ABC;
   localparam logic [47:0] C2 = 48'h123777555ABC;

   localparam int NV = 21;
   localparam vec_t TBL [NV] = '{
      '{4'd2, 1'b1, 8'h02, 16'h0002, 48'h0,            4'h0, 4'h0}, // R2 enable, direct
      '{4'd3, 1'b1, 8'h14, 16'h0ABC, 48'h000000000ABC, 4'h0, 4'h0}, // R3 ch0 direct
      '{4'd9, 1'b1, 8'h1A, 16'hF123, C1,               4'h0, 4'h0}, // R9 mask to 12 bits
      '{4'd4, 1'b1, 8'h02, 16'h0003, C1,               4'h0, 4'h0}, // R4 buffered
      '{4'd4, 1'b1, 8'h16, 16'h0555, C1,               4'h0, 4'h0}, // R4
      '{4'd4, 1'b1, 8'h18, 16'h0777, C1,               4'h0, 4'h0}, // R4
      '{4'd5, 1'b0, 8'h02, 16'h0000, C2,               4'h0, 4'h0}, // R5 transfer
      '{4'd7, 1'b1, 8'h12, 16'h0A50, C2,               4'h0, 4'h0}, // R7 staged only
      '{4'd7, 1'b0, 8'h12, 16'h0000, C2,               4'h5, 4'hA}, // R7 applied
      '{4'd4, 1'b1, 8'h14, 16'h0FFF, C2,               4'h5, 4'hA}, // R4
      '{4'd6, 1'b1, 8'h02, 16'h0002, C2,               4'h5, 4'hA}, // R6 back to direct
      '{4'd6, 1'b0, 8'h02, 16'h0000, C2,               4'h5, 4'hA}, // R6 read no effect
      '{4'd2, 1'b1, 8'h02, 16'h0001, 48'h0,            4'h5, 4'hA}, // R2 disable
      '{4'd2, 1'b1, 8'h02, 16'h0003, C2,               4'h5, 4'hA}, // R2 re-enable
      '{4'd9, 1'b1, 8'h30, 16'hFFFF, C2,               4'h5, 4'hA}, // R9 unmapped
      '{4'd9, 1'b0, 8'h14, 16'h0000, C2,               4'h5, 4'hA}, // R9 data read
      '{4'd8, 1'b1, 8'h12, 16'h0000, C2,               4'h5, 4'hA}, // R8
      '{4'd8, 1'b0, 8'h12, 16'h0000, C2,               4'h0, 4'h0}, // R8 cleared
      '{4'd8, 1'b1, 8'h02, 16'h0000, 48'h0,            4'h0, 4'h0}, // R8 codes zero
      '{4'd3, 1'b1, 8'h02, 16'h0002, C2,               4'h0, 4'h0}, // R3 direct again
      '{4'd3, 1'b1, 8'h16, 16'h0001, 48'h123777001ABC, 4'h0, 4'h0}  // R3 ch1 only
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_req = 1'b0;
   logic        host_we = 1'b0;
   logic [7:0]  host_addr = '0;
   logic [15:0] host_wdata = '0;
   logic [47:0] code_out;
   logic [3:0]  gain_out;
   logic [3:0]  bipolar_out;

   int n_run = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dac_dbuf_bank u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .host_req    (host_req),
      .host_we     (host_we),
      .host_addr   (host_addr),
      .host_wdata  (host_wdata),
      .code_out    (code_out),
      .gain_out    (gain_out),
      .bipolar_out (bipolar_out)
   );

   task automatic chk(input int req, input string what,
                      input logic [47:0] ec, input logic [3:0] eg, input logic [3:0] eb);
      n_run++;
      if (code_out !== ec || gain_out !== eg || bipolar_out !== eb) begin
         n_fail++;
         $display("FAIL R%0d %s: actual code=%h gain=%h bip=%h expected code=%h gain=%h bip=%h",
                  req, what, code_out, gain_out, bipolar_out, ec, eg, eb);
      end
   endtask

   task automatic access(input logic we, input logic [7:0] a, input logic [15:0] d);
      @(negedge clk);
      host_req   = 1'b1;
      host_we    = we;
      host_addr  = a;
      host_wdata = d;
      @(negedge clk);
      host_req   = 1'b0;
      host_we    = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(1, "reset state", 48'h0, 4'h0, 4'h0); // R1
      rst_n = 1'b1;
      @(negedge clk);
      chk(1, "after reset release", 48'h0, 4'h0, 4'h0); // R1

      for (int i = 0; i < NV; i++) begin
         access(TBL[i].we, TBL[i].addr, TBL[i].wd);
         chk(int'(TBL[i].req), $sformatf("step %0d", i), TBL[i].code, TBL[i].gn, TBL[i].bp);
      end

      // Mid-run reset with settings active: R1
      access(1'b1, 8'h12, 16'h0F00);
      access(1'b0, 8'h12, 16'h0000);
      chk(7, "all gains set", 48'h123777001ABC, 4'hF, 4'h0); // R7
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk(1, "mid-run reset", 48'h0, 4'h0, 4'h0); // R1
      @(negedge clk);
      rst_n = 1'b1;
      access(1'b1, 8'h02, 16'h0003);
      chk(1, "live cleared by reset", 48'h0, 4'h0, 4'h0); // R1
      access(1'b0, 8'h02, 16'h0000);
      chk(1, "staged cleared by reset", 48'h0, 4'h0, 4'h0); // R1
      access(1'b0, 8'h12, 16'h0000);
      chk(1, "staged control cleared", 48'h0, 4'h0, 4'h0); // R1

      // Bipolar positions alone: R7
      access(1'b1, 8'h12, 16'h00F0);
      access(1'b0, 8'h12, 16'h0000);
      chk(7, "all bipolar set", 48'h0, 4'h0, 4'hF); // R7

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL R1 watchdog: actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule